// File: doc/BRIEF.md
# SD host interrupt status controller

This block holds the interrupt bookkeeping of an SD host controller. Event pulses from the command, data, DMA and card-detect engines set latched status bits, but only for sources whose status-enable bit is on. Software reads the latched bits through a small register port and acknowledges them by writing ones. A separate signal-enable mask selects which latched bits drive the single interrupt line. A write-only force register lets software inject error conditions, and a companion register records the detailed cause of auto-CMD12 failures.

Two bits of the status word are not latches. Bit 8 tracks the card interrupt level as long as it is enabled, and bit 15 summarises all error bits. Writes cannot clear either of them. Register selection uses a 3-bit address: 0 is status, 1 is status-enable, 2 is signal-enable, 3 is force (it reads as zero), and 4 is auto-CMD12 error status. All other addresses read as zero. Reads are combinational from `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `sd_irq_status_ctrl`

## Requirements
- R1: After reset the status, both enable registers, the auto-CMD12 error register and `irq` are all zero.
- R2: A pulse on `evt_set[i]` sets latched status bit i at the next edge only when status-enable bit i is 1. Latched bits are 0–7, 9, 10, 16–25, 28 and 29. Pulses on other positions have no effect.
- R3: Writing status (address 0) clears each latched bit where the write data holds 1. Bits where the data holds 0 keep their value.
- R4: When a set (event, force or auto-CMD12 flag) and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 15 reads as the OR of status bits 16–29. A write cannot change it except by clearing those error bits.
- R6: Status bit 8 reads as `card_irq_lvl` AND status-enable bit 8, in the same cycle. Writing 1 to it does not clear it.
- R7: Status-enable (address 1) and signal-enable (address 2) store write data masked by 0x33FF07FF. Bit 15 and the unimplemented bits always read as 0.
- R8: Writing 1 to a latched error bit (16–25, 28, 29) of the force register (address 3) sets that status bit at the next edge, whatever the status-enable setting. Address 3 reads as 0.
- R9: The auto-CMD12 error register (address 4) has bits 0 not executed, 1 timeout, 2 CRC, 3 end bit, 4 index and 7 command not issued. Each bit is set by a pulse on `acmd_evt` or by a 1 in the same bit of a force-register write. The status-enable register does not gate it.
- R10: Status bit 24 sets whenever an auto-CMD12 error bit is set by force. When the bit is set by an `acmd_evt` pulse, status bit 24 sets only if status-enable bit 24 is 1.
- R11: A write-one clear of status bit 24 also empties the auto-CMD12 error register. Auto-CMD12 error bits set in that same cycle stay set.
- R12: `irq` is registered: it is the OR over all bits of (status as read AND signal-enable), taken one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Combinational read data |
| evt_set | input | 32 | Status event pulses, one per status bit position |
| card_irq_lvl | input | 1 | Card interrupt level |
| acmd_evt | input | 8 | Auto-CMD12 error pulses |
| irq | output | 1 | Interrupt request |

## Verification
Writes, event pulses and forced errors change the latched registers at the first rising edge after they are driven. Read data then follows on the same side of that edge, because the read path has no register. Bits 8 and 15 follow their inputs in the same cycle, while `irq` lags the read-visible status by one further edge. The bench drives inputs on the falling edge and lets one rising edge pass before it samples on the next falling edge. A reference model advances by exactly one state per rising edge, and `irq` is compared with the model's value computed from the state before that edge. Directed cases step idle cycles explicitly when they wait for the interrupt.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

   localparam int unsigned MAP_W = 32;

   // status bits that are real latches
   localparam logic [MAP_W-1:0] LATCH_MASK = 32'h33FF_06FF;
   // error half of the status word
   localparam logic [MAP_W-1:0] ERR_MASK   = 32'h33FF_0000;
   // storage bits of the two enable registers
   localparam logic [MAP_W-1:0] EN_MASK    = 32'h33FF_07FF;
   // implemented auto-CMD12 error bits
   localparam logic [7:0]       ACMD_MASK  = 8'h9F;

   localparam int unsigned CARD_BIT = 8;
   localparam int unsigned SUM_BIT  = 15;
   localparam int unsigned ACMD_BIT = 24;
   localparam int unsigned ERR_LO   = 16;
   localparam int unsigned ERR_HI   = 29;

   localparam int unsigned A_STATUS = 0;
   localparam int unsigned A_STS_EN = 1;
   localparam int unsigned A_SIG_EN = 2;
   localparam int unsigned A_FORCE  = 3;
   localparam int unsigned A_ACMD   = 4;

endpackage

// File: rtl/sd_irq_mask_reg.sv
module sd_irq_mask_reg #(
   parameter int unsigned          W    = 32,
   parameter logic [W-1:0]         MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & MASK;
   end

   AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & ~MASK) == '0)); // R7

endmodule

// File: rtl/sd_irq_status_array.sv
module sd_irq_status_array #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);

   logic [W-1:0] nxt;

   always_comb nxt = (set_vec | (q & ~clr_vec)) & MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec == '0) |=> ((q & ~$past(q)) == '0)); // R2

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((q & $past(clr_vec & ~set_vec)) == '0)); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & MASK) != '0) |=> ((q & $past(set_vec & MASK)) == $past(set_vec & MASK))); // R4

endmodule

// File: rtl/sd_irq_acmd_log.sv
module sd_irq_acmd_log #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         frc_we,
   input  logic [W-1:0] frc_data,
   input  logic         flush,
   output logic [W-1:0] q,
   output logic         evt_hit,
   output logic         frc_hit
);

   logic [W-1:0] evt_new;
   logic [W-1:0] frc_new;

   always_comb begin
      evt_new = evt & MASK;
      frc_new = frc_we ? (frc_data & MASK) : '0;
      evt_hit = |evt_new;
      frc_hit = |frc_new;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (flush ? '0 : q) | evt_new | frc_new;
   end

   AST_ACMD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !evt_hit && !frc_hit) |=> (q == '0)); // R11

   AST_ACMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush) |=> ((q & $past(q)) == $past(q))); // R9

endmodule

// File: rtl/sd_irq_status_ctrl.sv
module sd_irq_status_ctrl #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned ACMD_W   = 8,
   parameter bit          IRQ_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [REG_W-1:0]  evt_set,
   input  logic              card_irq_lvl,
   input  logic [ACMD_W-1:0] acmd_evt,
   output logic              irq
);
   import sd_irq_pkg::*;

   localparam logic [REG_W-1:0]  L_LATCH = REG_W'(LATCH_MASK);
   localparam logic [REG_W-1:0]  L_ERR   = REG_W'(ERR_MASK);
   localparam logic [REG_W-1:0]  L_EN    = REG_W'(EN_MASK);
   localparam logic [ACMD_W-1:0] L_ACMD  = ACMD_W'(ACMD_MASK);

   if (REG_W < ERR_HI + 1) begin : g_chk_w
      $error("REG_W too narrow for the status layout");
   end
   if (ADDR_W < 3) begin : g_chk_a
      $error("ADDR_W must reach five registers");
   end
   if (ACMD_W < 8) begin : g_chk_c
      $error("ACMD_W must hold bit 7");
   end

   logic              we_sts, we_sen, we_sig, we_frc;
   logic [REG_W-1:0]  sen_q, sig_q, sts_q, view;
   logic [REG_W-1:0]  set_vec, clr_vec;
   logic [ACMD_W-1:0] acmd_q;
   logic              acmd_evt_hit, acmd_frc_hit, acmd_flush;
   logic              irq_now;

   always_comb begin
      we_sts = wr_en && (wr_addr == ADDR_W'(A_STATUS));
      we_sen = wr_en && (wr_addr == ADDR_W'(A_STS_EN));
      we_sig = wr_en && (wr_addr == ADDR_W'(A_SIG_EN));
      we_frc = wr_en && (wr_addr == ADDR_W'(A_FORCE));
   end

   sd_irq_mask_reg #(.W(REG_W), .MASK(L_EN)) u_sts_en (
      .clk(clk), .rst_n(rst_n), .we(we_sen), .wdata(wr_data), .q(sen_q));

   sd_irq_mask_reg #(.W(REG_W), .MASK(L_EN)) u_sig_en (
      .clk(clk), .rst_n(rst_n), .we(we_sig), .wdata(wr_data), .q(sig_q));

   always_comb acmd_flush = we_sts && wr_data[ACMD_BIT];

   sd_irq_acmd_log #(.W(ACMD_W), .MASK(L_ACMD)) u_acmd (
      .clk(clk), .rst_n(rst_n), .evt(acmd_evt), .frc_we(we_frc),
      .frc_data(wr_data[ACMD_W-1:0]), .flush(acmd_flush), .q(acmd_q),
      .evt_hit(acmd_evt_hit), .frc_hit(acmd_frc_hit));

   always_comb begin
      set_vec = (evt_set & sen_q & L_LATCH) | (we_frc ? (wr_data & L_ERR) : '0);
      if ((acmd_evt_hit && sen_q[ACMD_BIT]) || acmd_frc_hit)
         set_vec[ACMD_BIT] = 1'b1;
      clr_vec = we_sts ? (wr_data & L_LATCH) : '0;
   end

   sd_irq_status_array #(.W(REG_W), .MASK(L_LATCH)) u_status (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(sts_q));

   always_comb begin
      view           = sts_q;
      view[CARD_BIT] = card_irq_lvl & sen_q[CARD_BIT];
      view[SUM_BIT]  = |(sts_q & L_ERR);
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_STATUS))      rd_data = view;
      else if (rd_addr == ADDR_W'(A_STS_EN)) rd_data = sen_q;
      else if (rd_addr == ADDR_W'(A_SIG_EN)) rd_data = sig_q;
      else if (rd_addr == ADDR_W'(A_ACMD))   rd_data = REG_W'(acmd_q);
   end

   always_comb irq_now = |(view & sig_q);

   if (IRQ_PIPE) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_now;
      end

      AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_now |=> irq); // R12
      AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_now |=> !irq); // R12
   end else begin : g_irq_comb
      always_comb irq = irq_now;
   end

   AST_ACMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      acmd_frc_hit |=> sts_q[ACMD_BIT]); // R10

   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      we_frc |=> ((sts_q & $past(wr_data & L_ERR)) == $past(wr_data & L_ERR))); // R8

   AST_CARD_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !sen_q[CARD_BIT] |-> !view[CARD_BIT]); // R6

endmodule

// File: tb/sd_irq_status_ctrl_bench.sv
module sd_irq_status_ctrl_bench;

   localparam logic [31:0] M_LATCH = 32'h33FF_06FF;
   localparam logic [31:0] M_ERR   = 32'h33FF_0000;
   localparam logic [31:0] M_EN    = 32'h33FF_07FF;
   localparam logic [7:0]  M_ACMD  = 8'h9F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] evt_set = '0;
   logic        card_irq_lvl = 1'b0;
   logic [7:0]  acmd_evt = '0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [31:0] m_sts = '0, m_sen = '0, m_sig = '0;
   logic [7:0]  m_acmd = '0;
   logic        m_irq = 1'b0;

   always #10ns clk = ~clk;

   sd_irq_status_ctrl u_sd_irq_status_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_set(evt_set), .card_irq_lvl(card_irq_lvl), .acmd_evt(acmd_evt),
      .irq(irq));

   function automatic logic [31:0] f_view(logic [31:0] s, logic [31:0] en, logic card);
      logic [31:0] v;
      v     = s;
      v[8]  = card & en[8];
      v[15] = |(s & M_ERR);
      return v;
   endfunction

   function automatic logic [31:0] f_read(logic [2:0] a);
      case (a)
         3'd0:    return f_view(m_sts, m_sen, card_irq_lvl);
         3'd1:    return m_sen;
         3'd2:    return m_sig;
         3'd4:    return {24'd0, m_acmd};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one rising edge with the current inputs; model advances alongside
   task automatic step();
      logic        ws, wse, wsg, wf, ahe, ahf;
      logic [31:0] set, clr, n_sts;
      logic [7:0]  ne, nf, n_acmd;
      ws  = wr_en && wr_addr == 3'd0;
      wse = wr_en && wr_addr == 3'd1;
      wsg = wr_en && wr_addr == 3'd2;
      wf  = wr_en && wr_addr == 3'd3;
      ne  = acmd_evt & M_ACMD;
      nf  = wf ? (wr_data[7:0] & M_ACMD) : 8'd0;
      ahe = |ne;
      ahf = |nf;
      set = (evt_set & m_sen & M_LATCH) | (wf ? (wr_data & M_ERR) : 32'd0);
      if ((ahe && m_sen[24]) || ahf) set[24] = 1'b1;
      clr    = ws ? (wr_data & M_LATCH) : 32'd0;
      n_sts  = set | (m_sts & ~clr);
      n_acmd = ((ws && wr_data[24]) ? 8'd0 : m_acmd) | ne | nf;
      @(posedge clk);
      m_irq  = |(f_view(m_sts, m_sen, card_irq_lvl) & m_sig);
      m_sts  = n_sts;
      m_acmd = n_acmd;
      if (wse) m_sen = wr_data & M_EN;
      if (wsg) m_sig = wr_data & M_EN;
      @(negedge clk);
      wr_en    = 1'b0;
      evt_set  = '0;
      acmd_evt = '0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
   endtask

   task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);

      // R7 enable masks
      wr(3'd1, 32'hFFFF_FFFF);
      rd_chk("R7 sts_en", 3'd1, 32'h33FF_07FF);
      wr(3'd2, 32'hFFFF_FFFF);
      rd_chk("R7 sig_en", 3'd2, 32'h33FF_07FF);
      wr(3'd2, 32'd0);

      // R2 gating by status-enable
      wr(3'd1, 32'd0);
      evt_set = 32'h0000_0001; step();
      rd_chk("R2 gated", 3'd0, 32'd0);
      wr(3'd1, 32'hFFFF_FFFF);
      evt_set = 32'hCC00_F901; step();
      rd_chk("R2 set", 3'd0, 32'h0000_0001);

      // R3 write zero keeps, write one clears
      wr(3'd0, 32'd0);
      rd_chk("R3 keep", 3'd0, 32'h0000_0001);
      wr(3'd0, 32'h0000_0001);
      rd_chk("R3 clear", 3'd0, 32'd0);

      // R4 set beats clear
      evt_set = 32'h0000_0002; wr(3'd0, 32'h0000_0002);
      rd_chk("R4", 3'd0, 32'h0000_0002);
      wr(3'd0, 32'h0000_0002);

      // R6 card interrupt level
      card_irq_lvl = 1'b1; #1;
      rd_chk("R6 follow", 3'd0, 32'h0000_0100);
      wr(3'd0, 32'h0000_0100);
      rd_chk("R6 no clear", 3'd0, 32'h0000_0100);
      wr(3'd1, 32'h33FF_06FF);
      rd_chk("R6 gated", 3'd0, 32'd0);
      card_irq_lvl = 1'b0;

      // R8 force ignores enable; R5 summary
      wr(3'd1, 32'd0);
      wr(3'd3, 32'h0010_0000);
      rd_chk("R8 force", 3'd0, 32'h0010_8000);
      rd_chk("R8 reads0", 3'd3, 32'd0);
      wr(3'd0, 32'h0000_8000);
      rd_chk("R5 not writable", 3'd0, 32'h0010_8000);
      wr(3'd0, 32'h0010_0000);
      rd_chk("R5 follows", 3'd0, 32'd0);

      // R9 / R10 auto-CMD12 log
      acmd_evt = 8'h04; step();
      rd_chk("R9 evt", 3'd4, 32'h0000_0004);
      rd_chk("R10 gated", 3'd0, 32'd0);
      wr(3'd1, 32'h0100_0000);
      acmd_evt = 8'h60; step();
      rd_chk("R9 unimpl", 3'd4, 32'h0000_0004);
      rd_chk("R10 unimpl", 3'd0, 32'd0);
      acmd_evt = 8'h01; step();
      rd_chk("R10 evt", 3'd0, 32'h0100_8000);
      wr(3'd1, 32'd0);
      wr(3'd3, 32'h0000_0080);
      rd_chk("R9 force", 3'd4, 32'h0000_0085);

      // R11 flush, with new bits winning
      acmd_evt = 8'h02; wr(3'd0, 32'h0100_0000);
      rd_chk("R11 keep new", 3'd4, 32'h0000_0002);
      wr(3'd0, 32'h0100_0000);
      rd_chk("R11 flush", 3'd4, 32'd0);

      // R12 irq one edge after status
      wr(3'd1, 32'h0000_0001);
      wr(3'd2, 32'h0000_0001);
      evt_set = 32'h1; step();
      chk("R12 not yet", {31'd0, irq}, 32'd0);
      step();
      chk("R12 raised", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h1);
      chk("R12 still", {31'd0, irq}, 32'd1);
      step();
      chk("R12 dropped", {31'd0, irq}, 32'd0);

      // randomised traffic against the model
      for (int n = 0; n < 3000; n++) begin
         if (($urandom % 3) == 0) begin
            wr_en   = 1'b1;
            wr_addr = 3'($urandom % 6);
            wr_data = $urandom | ($urandom & $urandom);
         end
         evt_set      = $urandom & $urandom & $urandom;
         card_irq_lvl = 1'($urandom);
         acmd_evt     = (($urandom % 8) == 0) ? 8'($urandom) : 8'd0;
         step();
         chk("R12 rand", {31'd0, irq}, {31'd0, m_irq});
         begin
            logic [2:0] a;
            a = 3'($urandom % 6);
            rd_chk("R2 rand", a, f_read(a));
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule